// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block serves a shared word-addressed memory to several requesters, for example four cores. Each requester can issue a plain load, a plain store, a load-linked or a store-conditional. One request is granted per cycle by fixed priority, and its response returns one cycle later on a shared response bus. The block keeps one reservation per requester, made of a valid flag and a word address, and it watches every write that lands in memory.

A load-linked returns the memory word and arms the issuer's reservation on that word. A later store-conditional from the same requester succeeds only if no write has reached that word in the meantime. In that case it writes and returns 1. Otherwise it writes nothing and returns 0. Software places that result in the register that held the store data, so it must keep a copy of the data if it wants to retry. This makes swap and test-and-set sequences atomic without locking the memory port. A lock word of 0 means free and 1 means held, and a plain store of 0 releases the lock.

Each reservation slot is a two-state machine. In `RSV_EMPTY` it holds no reservation. An own load-linked moves it to `RSV_ARMED` (transition *arm*). In `RSV_ARMED`, a new own load-linked stays armed and takes the new address (*rearm*). An own store-conditional, whatever its outcome (*consume*), returns the slot to `RSV_EMPTY`. So does any write to the reserved word, whether a store or a successful store-conditional (*snoop-kill*).

Top module: `llsc_monitor`

## Requirements
- R1: After reset, no response is valid, every memory word reads 0, and every reservation is empty, so a store-conditional fails.
- R2: Among the requesters holding `req_valid`, exactly one is granted per cycle: the one with the lowest index. A requester that is not requesting is never granted. Each requester keeps its request up until the cycle in which it is granted.
- R3: A grant at one clock edge produces `resp_valid` after that edge for exactly one cycle, with `resp_id` equal to the granted index.
- R4: The op code has 2 bits per requester: 00 load, 01 store, 10 load-linked, 11 store-conditional. A load returns the addressed word. A store writes `wdata` to the word and responds with 0.
- R5: A load-linked returns the word and arms the issuer's reservation. A store-conditional to the same word with no write in between returns 1 and writes its data.
- R6: A plain store by another requester to the reserved word makes the later store-conditional return 0 and leave memory unchanged.
- R7: When two requesters both hold a reservation on one word, the first successful store-conditional makes the other's store-conditional fail.
- R8: A store-conditional to a word other than the reserved one returns 0 and writes nothing.
- R9: Every store-conditional clears the issuer's reservation, so a second store-conditional with no new load-linked fails.
- R10: A write to a different word leaves a reservation intact.
- R11: Test-and-set loops run by all requesters at once never let two of them hold the lock. A shared counter updated inside the critical section increments exactly once per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request strobe per requester, held until granted |
| req_op | input | 2*NREQ | Op code per requester (00 load, 01 store, 10 load-linked, 11 store-conditional) |
| req_addr | input | NREQ*AW | Word address per requester |
| req_wdata | input | NREQ*DW | Store data per requester |
| gnt | output | NREQ | Combinational one-hot grant; the op executes at the next edge |
| resp_valid | output | 1 | Response strobe, one cycle after the grant |
| resp_id | output | $clog2(NREQ) | Index of the responding requester |
| resp_data | output | DW | Loaded word, store-conditional result (1/0), or 0 for a store |

## Verification
The bench builds the block with its defaults: four requesters, 64 words and 32-bit data. With four requesters, a three-deep priority chain and four-way contention on one lock word are both reachable. The directed part crosses reservations between requesters on one word and on two different words. Contended test-and-set loops from all four requesters then stress snoop-kill and the consume transition under real races.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LL    = 2'b10,
        OP_SC    = 2'b11
    } op_e;

    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_ARMED = 1'b1
    } rsv_state_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int IW = $clog2(N);

    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                found  = 1'b1;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
        any = found;
    end
endmodule

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot
    import llsc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [AW-1:0] arm_addr,
    input  logic          consume,
    input  logic          snoop_wr,
    input  logic [AW-1:0] snoop_addr,
    output logic          armed,
    output logic [AW-1:0] rsv_addr
);
    rsv_state_e    state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (arm) begin
                    state_d = RSV_ARMED;
                    addr_d  = arm_addr;
                end
            end
            RSV_ARMED: begin
                if (arm) begin
                    addr_d = arm_addr;
                end else if (consume || (snoop_wr && snoop_addr == addr_q)) begin
                    state_d = RSV_EMPTY;
                end
            end
            default: state_d = RSV_EMPTY;
        endcase
    end

    always_comb begin
        armed    = (state_q == RSV_ARMED);
        rsv_addr = addr_q;
    end
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 6,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREQ-1:0]         req_valid,
    input  logic [2*NREQ-1:0]       req_op,
    input  logic [NREQ*AW-1:0]      req_addr,
    input  logic [NREQ*DW-1:0]      req_wdata,
    output logic [NREQ-1:0]         gnt,
    output logic                    resp_valid,
    output logic [$clog2(NREQ)-1:0] resp_id,
    output logic [DW-1:0]           resp_data
);
    localparam int IDW = $clog2(NREQ);

    logic [IDW-1:0] sel;
    logic           any_gnt;
    op_e            cur_op;
    logic [AW-1:0]  cur_addr;
    logic [DW-1:0]  cur_wdata;
    logic [DW-1:0]  rd_word;
    logic [NREQ-1:0] armed;
    logic [AW-1:0]  rsv_addr [NREQ];
    logic           ll_issue, sc_issue, sc_ok, wr_en;

    llsc_arbiter #(.N(NREQ)) u_arb (
        .req (req_valid),
        .gnt (gnt),
        .idx (sel),
        .any (any_gnt)
    );

    always_comb begin
        cur_op    = op_e'(req_op[int'(sel)*2 +: 2]);
        cur_addr  = req_addr[int'(sel)*AW +: AW];
        cur_wdata = req_wdata[int'(sel)*DW +: DW];
        ll_issue  = any_gnt && (cur_op == OP_LL);
        sc_issue  = any_gnt && (cur_op == OP_SC);
        sc_ok     = sc_issue && armed[sel] && (rsv_addr[sel] == cur_addr);
        wr_en     = (any_gnt && cur_op == OP_STORE) || sc_ok;
    end

    for (genvar g = 0; g < NREQ; g++) begin : g_slot
        llsc_rsv_slot #(.AW(AW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm        (ll_issue && sel == IDW'(g)),
            .arm_addr   (cur_addr),
            .consume    (sc_issue && sel == IDW'(g)),
            .snoop_wr   (wr_en),
            .snoop_addr (cur_addr),
            .armed      (armed[g]),
            .rsv_addr   (rsv_addr[g])
        );
    end

    llsc_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .addr  (cur_addr),
        .wdata (cur_wdata),
        .rdata (rd_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_id    <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= any_gnt;
            if (any_gnt) begin
                resp_id <= sel;
                unique case (cur_op)
                    OP_SC:    resp_data <= DW'(sc_ok);
                    OP_STORE: resp_data <= '0;
                    default:  resp_data <= rd_word;
                endcase
            end
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int NREQ = 4,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] req_valid,
    input logic [NREQ-1:0] gnt,
    input logic            resp_valid,
    input logic [DW-1:0]   resp_data,
    input logic            sc_issue
);
    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R2
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req_valid) == '0);
    // R2
    grant_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> gnt[0]);
    // R2
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |-> (|gnt));
    // R3
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> resp_valid);
    // R3
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gnt) |=> !resp_valid);
    // R5
    sc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_issue |=> (resp_data <= DW'(1)));
endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .gnt        (gnt),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .sc_issue   (sc_issue)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
    localparam int NREQ = 4, AW = 6, DW = 32, ITER = 5;
    localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;
    localparam logic [AW-1:0] LOCK = 6'd20, CNT = 6'd21;

    logic clk = 0, rst_n = 0;
    logic [NREQ-1:0]    req_valid = '0;
    logic [2*NREQ-1:0]  req_op = '0;
    logic [NREQ*AW-1:0] req_addr = '0;
    logic [NREQ*DW-1:0] req_wdata = '0;
    logic [NREQ-1:0]    gnt;
    logic               resp_valid;
    logic [1:0]         resp_id;
    logic [DW-1:0]      resp_data;

    llsc_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .gnt(gnt),
        .resp_valid(resp_valid), .resp_id(resp_id), .resp_data(resp_data)
    );

    always #5 clk = ~clk;

    typedef struct { int id; logic [DW-1:0] data; string tag; } exp_t;
    exp_t sb_q[$];
    bit sb_on = 1;
    int nchk = 0, nerr = 0, holders = 0, crit_done = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Driver: issues one request, pushes the expected response into the scoreboard
    task automatic do_op(input int i, input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic [DW-1:0] exp,
                         input string tag, output logic [DW-1:0] got);
        @(negedge clk);
        req_op[i*2 +: 2]     = op;
        req_addr[i*AW +: AW] = a;
        req_wdata[i*DW +: DW] = wd;
        req_valid[i] = 1'b1;
        forever begin
            #1;
            if (gnt[i]) break;
            @(negedge clk);
        end
        if (sb_on) sb_q.push_back('{id: i, data: exp, tag: tag});
        @(negedge clk);
        req_valid[i] = 1'b0;
        chk(resp_valid && resp_id == 2'(i), "R3", {30'd0, resp_id}, i);
        got = resp_data;
    endtask

    // Monitor: pops and compares each response
    always @(negedge clk) begin
        if (rst_n && sb_on && resp_valid) begin
            if (sb_q.size() == 0) begin
                chk(0, "R3 unexpected response", resp_data, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(resp_id == 2'(e.id) && resp_data == e.data, e.tag, resp_data, e.data);
            end
        end
    end

    task automatic tas(input int i);
        logic [DW-1:0] v, c;
        for (int k = 0; k < ITER; k++) begin
            bit got_lock;
            got_lock = 0;
            while (!got_lock) begin
                do_op(i, LL, LOCK, 0, 0, "R11", v);
                if (v == 0) begin
                    do_op(i, SC, LOCK, 1, 0, "R11", v);
                    got_lock = (v == 1);
                end
            end
            holders++;
            chk(holders == 1, "R11 mutual exclusion", holders, 1);
            do_op(i, LD, CNT, 0, 0, "R11", c);
            chk(c == crit_done, "R11 counter", c, crit_done);
            do_op(i, ST, CNT, c + 1, 0, "R11", v);
            crit_done++;
            holders--;
            do_op(i, ST, LOCK, 0, 0, "R11", v);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        chk(resp_valid == 0, "R1 no response in reset", resp_valid, 0);
        rst_n = 1;
        // R1: empty reservations, zeroed memory
        do_op(0, SC, 6'd3, 32'h7, 0, "R1", v);
        do_op(1, LD, 6'd3, 0, 0, "R1", v);
        // R4: store then load
        do_op(0, ST, 6'd5, 32'h11, 0, "R4", v);
        do_op(1, LD, 6'd5, 0, 32'h11, "R4", v);
        // R5: LL then SC success
        do_op(2, LL, 6'd5, 0, 32'h11, "R5", v);
        do_op(2, SC, 6'd5, 32'h22, 1, "R5", v);
        do_op(1, LD, 6'd5, 0, 32'h22, "R5", v);
        // R9: reservation consumed
        do_op(2, SC, 6'd5, 32'h33, 0, "R9", v);
        do_op(1, LD, 6'd5, 0, 32'h22, "R9", v);
        // R6: intervening plain store
        do_op(1, LL, 6'd5, 0, 32'h22, "R6", v);
        do_op(3, ST, 6'd5, 32'h44, 0, "R6", v);
        do_op(1, SC, 6'd5, 32'h55, 0, "R6", v);
        do_op(0, LD, 6'd5, 0, 32'h44, "R6", v);
        // R7: competing reservations
        do_op(0, LL, 6'd5, 0, 32'h44, "R7", v);
        do_op(1, LL, 6'd5, 0, 32'h44, "R7", v);
        do_op(1, SC, 6'd5, 32'h66, 1, "R7", v);
        do_op(0, SC, 6'd5, 32'h77, 0, "R7", v);
        do_op(2, LD, 6'd5, 0, 32'h66, "R7", v);
        // R8: SC to another word
        do_op(0, LL, 6'd5, 0, 32'h66, "R8", v);
        do_op(0, SC, 6'd9, 32'h1, 0, "R8", v);
        do_op(2, LD, 6'd9, 0, 0, "R8", v);
        // R10: write elsewhere keeps reservation
        do_op(3, LL, 6'd5, 0, 32'h66, "R10", v);
        do_op(2, ST, 6'd9, 32'h99, 0, "R10", v);
        do_op(3, SC, 6'd5, 32'hAA, 1, "R10", v);
        do_op(0, LD, 6'd5, 0, 32'hAA, "R10", v);
        // R2: simultaneous requests, lowest index first
        fork
            begin logic [DW-1:0] a; do_op(2, LD, 6'd9, 0, 32'h99, "R2", a); end
            begin logic [DW-1:0] b; do_op(1, LD, 6'd5, 0, 32'hAA, "R2", b); end
            begin @(negedge clk); #2; chk(gnt == 4'b0010, "R2 priority", {28'd0, gnt}, 32'h2); end
        join
        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "R3 all responses seen", sb_q.size(), 0);
        // R11: contended test-and-set
        sb_on = 0;
        fork
            tas(0);
            tas(1);
            tas(2);
            tas(3);
        join
        do_op(0, LD, CNT, 0, 0, "R11", v);
        chk(v == NREQ * ITER, "R11 final counter", v, NREQ * ITER);
        do_op(0, LD, LOCK, 0, 0, "R11", v);
        chk(v == 0, "R11 lock released", v, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule